// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative TLB

This block is a 64-entry fully associative translation lookaside buffer for a 64-bit virtual address space with 13-bit address-space contexts. Each entry sets its own page size. The size is 8 KB times a power of eight, up to 4 MB, so one small structure holds mappings of mixed granularity. A single lookup port presents a virtual address, a context selector, an access kind and the privilege mode. One cycle later the block returns a 41-bit physical address, a write-permission flag and a byte-swap attribute. Otherwise it flags a miss, an access fault (privilege, side-effect or no-fault-only) or a protection fault.

Entries are loaded through a write port by an external refill agent. The choice of victim and the table walk are outside this block. When a lookup faults, the block records it in a fault status register and a fault address register. When a lookup faults or misses, it loads a tag-access register that the refill agent reads to build the new entry. A bypass input turns translation off, and the address is then passed straight through.

Top module: `multisize_tlb`

## Requirements
- R1: After reset every entry is invalid and every used bit is clear. `faultStatus`, `faultAddr`, `tagAccess`, `rspValid` and all response flags are zero.
- R2: An entry hits when all three of these hold: it is valid; it is global (wrFlags[1]) or its context equals the lookup context; and its stored VA equals the lookup VA on all bits at and above bit 13+3·size. The size field `wrSize` 0/1/2/3 gives 8 KB/64 KB/512 KB/4 MB pages.
- R3: On a hit, `rspPa` takes the entry's physical address above the page offset and the lookup VA inside the page offset. Bits 12:0 are forced to zero.
- R4: `lkCtxSel` = 0 selects `ctxPrimary` and 1 selects `ctxSecondary`. Values 2 and 3 select the nucleus context, which is 0.
- R5: `rspHitVec` is one-hot or zero. If several entries hit, the lowest-numbered entry is the one used.
- R6: A lookup that hits no entry raises `rspMiss` and drives `rspPa` to zero. It loads `tagAccess` with {VA[63:13], context}. `faultStatus` and `faultAddr` keep their values, unless `statusClr` clears the status.
- R7: A lookup with `lkUser`=1 that hits an entry with the privileged flag (wrFlags[2]) is an access fault, and it sets status bit 6.
- R8: `lkKind` encodes 0 load, 1 store, 2 fetch and 3 no-fault load. A no-fault load that hits a side-effect entry (wrFlags[4]) sets status bit 7. A load or store that hits a no-fault-only entry (wrFlags[5]) sets status bit 8. Any of bits 6 to 8 raises `rspAccessFault`, and several of them may be set together. A fetch is checked for privilege only.
- R9: A store that hits an entry without write permission (wrFlags[3]) raises `rspProtFault`, but only when no access fault is raised. It never raises both.
- R10: On an access or protection fault, `faultStatus` is replaced by the following fields: [0]=1; [1]=the previous value of bit 0; [2]=store; [4:3]=context type (0 primary, 1 secondary, 2 nucleus); [5]=privileged mode; [8:6]=the fault-type bits. `faultAddr` takes the VA and `tagAccess` is loaded as in R6. When no fault is recorded, `statusClr` clears `faultStatus` to zero.
- R11: A hit without any fault sets that entry's bit in `entryUsed`, and a write to an entry clears its used bit. On every hit, `rspSwap` is the entry's invert-endian flag (wrFlags[6]) and `rspWritable` is its write flag.
- R12: With `lkBypass`=1 the response carries `rspPa`=VA[40:0], `rspWritable`=1, and no miss, fault, swap or hit. No register or used bit is changed apart from the effect of `statusClr`.
- R13: Each response appears exactly one cycle after its lookup. `rspValid` follows `lkValid` with a one-cycle delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Load entry `wrIdx` |
| wrIdx | input | 6 | Entry to load |
| wrVa | input | 64 | Virtual address tag of the entry (bits 12:0 ignored) |
| wrCtx | input | 13 | Context of the entry |
| wrPa | input | 41 | Physical address of the entry (bits 12:0 ignored) |
| wrSize | input | 2 | Page size code |
| wrFlags | input | 7 | valid, global, privileged, writable, side-effect, no-fault-only, invert-endian (bit 0 to 6) |
| lkValid | input | 1 | Lookup request |
| lkVa | input | 64 | Lookup virtual address |
| lkCtxSel | input | 2 | Context selector |
| lkKind | input | 2 | Access kind |
| lkUser | input | 1 | Access made in user mode |
| lkBypass | input | 1 | Translation off |
| ctxPrimary | input | 13 | Primary context |
| ctxSecondary | input | 13 | Secondary context |
| statusClr | input | 1 | Clear fault status |
| rspValid | output | 1 | Response valid |
| rspPa | output | 41 | Physical address |
| rspWritable | output | 1 | Write permission |
| rspSwap | output | 1 | Byte-swap attribute |
| rspMiss | output | 1 | No entry hit |
| rspAccessFault | output | 1 | Privilege, side-effect or no-fault-only fault |
| rspProtFault | output | 1 | Store to read-only page |
| rspHitVec | output | 64 | One-hot vector of the chosen entry |
| entryUsed | output | 64 | Used bit per entry |
| faultStatus | output | 9 | Fault status register |
| faultAddr | output | 64 | Fault address register |
| tagAccess | output | 64 | Tag-access register |

## Verification
The assertions assume that `lkValid` is never X out of reset and that the lookup inputs hold steady for the whole cycle in which `lkValid` is high. They also assume that no write lands on an entry in the same cycle as a lookup that could hit it. The bench drives every input at the falling edge and never overlaps a write with a lookup. It draws virtual addresses and contexts from small pools, so random lookups produce frequent hits, multiple hits across different page sizes, and misses.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VaW     = 64;
  localparam int PaW     = 41;
  localparam int CtxW    = 13;
  localparam int PageLsb = 13;
  localparam int StatW   = 9;

  typedef enum logic [1:0] {
    KIND_LOAD   = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_FETCH  = 2'd2,
    KIND_NFLOAD = 2'd3
  } kind_e;

  typedef struct packed {
    logic                   valid;
    logic                   global;
    logic                   priv;
    logic                   writable;
    logic                   sideEff;
    logic                   nfoOnly;
    logic                   invEnd;
    logic [1:0]             size;
    logic [CtxW-1:0]        ctx;
    logic [VaW-1:PageLsb]   vaTag;
    logic [PaW-1:PageLsb]   paTag;
  } entry_t;

  typedef struct packed {
    logic markUsed;
  } strobe_t;

  function automatic logic [VaW-1:PageLsb] sizeMask(input logic [1:0] sz);
    logic [VaW-1:PageLsb] one;
    one = 1;
    return ~((one << (3 * sz)) - one);
  endfunction
endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int NumEntries = 64,
  localparam int IdxW = $clog2(NumEntries)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [IdxW-1:0]       wrIdx,
  input  entry_t                wrEntry,
  input  logic [VaW-1:0]        lkVa,
  input  logic [CtxW-1:0]       lkCtx,
  input  strobe_t               strobe,
  output logic [NumEntries-1:0] hitVec,
  output logic                  hitAny,
  output entry_t                hitEntry,
  output logic [PaW-1:0]        paOut,
  output logic [NumEntries-1:0] usedVec
);
  entry_t                mem [NumEntries];
  logic [NumEntries-1:0] rawHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NumEntries; i++) mem[i] <= '0;
      usedVec <= '0;
    end else begin
      if (wrEn) begin
        mem[wrIdx]     <= wrEntry;
        usedVec[wrIdx] <= 1'b0;
      end
      if (strobe.markUsed) usedVec <= usedVec | hitVec;
    end
  end

  for (genvar g = 0; g < NumEntries; g++) begin : gMatch
    logic [VaW-1:PageLsb] cmpMask;
    assign cmpMask   = sizeMask(mem[g].size);
    assign rawHit[g] = mem[g].valid && (mem[g].global || mem[g].ctx == lkCtx) &&
                       (((lkVa[VaW-1:PageLsb] ^ mem[g].vaTag) & cmpMask) == '0);
  end

  assign hitVec = rawHit & (~rawHit + NumEntries'(1));
  assign hitAny = |rawHit;

  always_comb begin
    hitEntry = '0;
    for (int i = 0; i < NumEntries; i++)
      if (hitVec[i]) hitEntry = hitEntry | mem[i];
  end

  logic [VaW-1:PageLsb] selMask;
  assign selMask = sizeMask(hitEntry.size);
  assign paOut = {(hitEntry.paTag & selMask[PaW-1:PageLsb]) |
                  (lkVa[PaW-1:PageLsb] & ~selMask[PaW-1:PageLsb]),
                  {PageLsb{1'b0}}};
endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
#(
  parameter int NumEntries = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lkValid,
  input  logic [VaW-1:0]        lkVa,
  input  logic [1:0]            lkCtxSel,
  input  logic [1:0]            lkKind,
  input  logic                  lkUser,
  input  logic                  lkBypass,
  input  logic [CtxW-1:0]       ctxPrimary,
  input  logic [CtxW-1:0]       ctxSecondary,
  input  logic                  statusClr,
  input  logic                  hitAny,
  input  logic [NumEntries-1:0] hitVec,
  input  entry_t                hitEntry,
  input  logic [PaW-1:0]        paIn,
  output logic [CtxW-1:0]       lkCtx,
  output strobe_t               strobe,
  output logic                  rspValid,
  output logic [PaW-1:0]        rspPa,
  output logic                  rspWritable,
  output logic                  rspSwap,
  output logic                  rspMiss,
  output logic                  rspAccessFault,
  output logic                  rspProtFault,
  output logic [NumEntries-1:0] rspHitVec,
  output logic [StatW-1:0]      faultStatus,
  output logic [VaW-1:0]        faultAddr,
  output logic [VaW-1:0]        tagAccess
);
  kind_e      kind;
  logic [1:0] ctxType;
  logic       ftPriv, ftSide, ftNfo, accF, protF, translate, recFault;

  assign kind = kind_e'(lkKind);

  always_comb begin
    unique case (lkCtxSel)
      2'd0:    begin lkCtx = ctxPrimary;   ctxType = 2'd0; end
      2'd1:    begin lkCtx = ctxSecondary; ctxType = 2'd1; end
      default: begin lkCtx = '0;           ctxType = 2'd2; end
    endcase
  end

  assign translate = lkValid && !lkBypass;
  assign ftPriv    = hitAny && lkUser && hitEntry.priv;
  assign ftSide    = hitAny && kind == KIND_NFLOAD && hitEntry.sideEff;
  assign ftNfo     = hitAny && (kind == KIND_LOAD || kind == KIND_STORE) && hitEntry.nfoOnly;
  assign accF      = ftPriv || ftSide || ftNfo;
  assign protF     = hitAny && !accF && kind == KIND_STORE && !hitEntry.writable;
  assign recFault  = translate && (accF || protF);

  assign strobe.markUsed = translate && hitAny && !accF && !protF;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;  rspPa <= '0;   rspWritable <= 1'b0; rspSwap <= 1'b0;
      rspMiss <= 1'b0;   rspAccessFault <= 1'b0; rspProtFault <= 1'b0;
      rspHitVec <= '0;   faultStatus <= '0; faultAddr <= '0; tagAccess <= '0;
    end else begin
      rspValid <= lkValid;
      if (lkValid) begin
        if (lkBypass) begin
          rspPa <= lkVa[PaW-1:0];  rspWritable <= 1'b1; rspSwap <= 1'b0;
          rspMiss <= 1'b0; rspAccessFault <= 1'b0; rspProtFault <= 1'b0;
          rspHitVec <= '0;
        end else begin
          rspPa          <= hitAny ? paIn : '0;
          rspWritable    <= hitAny && hitEntry.writable;
          rspSwap        <= hitAny && hitEntry.invEnd;
          rspMiss        <= !hitAny;
          rspAccessFault <= accF;
          rspProtFault   <= protF;
          rspHitVec      <= hitVec;
        end
      end
      if (recFault) begin
        faultStatus <= {ftNfo, ftSide, ftPriv, !lkUser, ctxType,
                        kind == KIND_STORE, faultStatus[0], 1'b1};
        faultAddr   <= lkVa;
      end else if (statusClr) begin
        faultStatus <= '0;
      end
      if (recFault || (translate && !hitAny))
        tagAccess <= {lkVa[VaW-1:PageLsb], lkCtx};
    end
  end
endmodule

// File: rtl/multisize_tlb.sv
module multisize_tlb
  import tlb_pkg::*;
#(
  parameter int NumEntries = 64,
  localparam int IdxW = $clog2(NumEntries)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [IdxW-1:0]       wrIdx,
  input  logic [63:0]           wrVa,
  input  logic [12:0]           wrCtx,
  input  logic [40:0]           wrPa,
  input  logic [1:0]            wrSize,
  input  logic [6:0]            wrFlags,
  input  logic                  lkValid,
  input  logic [63:0]           lkVa,
  input  logic [1:0]            lkCtxSel,
  input  logic [1:0]            lkKind,
  input  logic                  lkUser,
  input  logic                  lkBypass,
  input  logic [12:0]           ctxPrimary,
  input  logic [12:0]           ctxSecondary,
  input  logic                  statusClr,
  output logic                  rspValid,
  output logic [40:0]           rspPa,
  output logic                  rspWritable,
  output logic                  rspSwap,
  output logic                  rspMiss,
  output logic                  rspAccessFault,
  output logic                  rspProtFault,
  output logic [NumEntries-1:0] rspHitVec,
  output logic [NumEntries-1:0] entryUsed,
  output logic [8:0]            faultStatus,
  output logic [63:0]           faultAddr,
  output logic [63:0]           tagAccess
);
  entry_t                wrEntry, hitEntry;
  strobe_t               strobe;
  logic [NumEntries-1:0] hitVec;
  logic                  hitAny;
  logic [PaW-1:0]        paTrans;
  logic [CtxW-1:0]       lkCtx;

  always_comb begin
    wrEntry          = '0;
    wrEntry.valid    = wrFlags[0];
    wrEntry.global   = wrFlags[1];
    wrEntry.priv     = wrFlags[2];
    wrEntry.writable = wrFlags[3];
    wrEntry.sideEff  = wrFlags[4];
    wrEntry.nfoOnly  = wrFlags[5];
    wrEntry.invEnd   = wrFlags[6];
    wrEntry.size     = wrSize;
    wrEntry.ctx      = wrCtx;
    wrEntry.vaTag    = wrVa[VaW-1:PageLsb];
    wrEntry.paTag    = wrPa[PaW-1:PageLsb];
  end

  tlb_datapath #(.NumEntries(NumEntries)) i_datapath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrEntry(wrEntry),
    .lkVa(lkVa), .lkCtx(lkCtx), .strobe(strobe), .hitVec(hitVec),
    .hitAny(hitAny), .hitEntry(hitEntry), .paOut(paTrans), .usedVec(entryUsed)
  );

  tlb_control #(.NumEntries(NumEntries)) i_control (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVa(lkVa), .lkCtxSel(lkCtxSel),
    .lkKind(lkKind), .lkUser(lkUser), .lkBypass(lkBypass),
    .ctxPrimary(ctxPrimary), .ctxSecondary(ctxSecondary), .statusClr(statusClr),
    .hitAny(hitAny), .hitVec(hitVec), .hitEntry(hitEntry), .paIn(paTrans),
    .lkCtx(lkCtx), .strobe(strobe), .rspValid(rspValid), .rspPa(rspPa),
    .rspWritable(rspWritable), .rspSwap(rspSwap), .rspMiss(rspMiss),
    .rspAccessFault(rspAccessFault), .rspProtFault(rspProtFault),
    .rspHitVec(rspHitVec), .faultStatus(faultStatus), .faultAddr(faultAddr),
    .tagAccess(tagAccess)
  );
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int NumEntries = 64
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  lkValid,
  input logic                  lkBypass,
  input logic [63:0]           lkVa,
  input logic                  rspValid,
  input logic [40:0]           rspPa,
  input logic                  rspMiss,
  input logic                  rspAccessFault,
  input logic                  rspProtFault,
  input logic [NumEntries-1:0] rspHitVec,
  input logic [8:0]            faultStatus
);
  AST_HITVEC_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $onehot0(rspHitVec)); // R5
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspMiss |-> rspHitVec == '0 && !rspAccessFault && !rspProtFault); // R6
  AST_PROT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspProtFault |-> !rspAccessFault); // R9
  AST_FAULT_LOGGED: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && (rspAccessFault || rspProtFault) |-> faultStatus[0]); // R10
  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    lkValid && lkBypass |=> rspValid && !rspMiss && rspPa == $past(lkVa[40:0])); // R12
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid); // R13
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid); // R13
endmodule

bind multisize_tlb tlb_checker #(.NumEntries(NumEntries)) u_checker (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkBypass(lkBypass), .lkVa(lkVa),
  .rspValid(rspValid), .rspPa(rspPa), .rspMiss(rspMiss),
  .rspAccessFault(rspAccessFault), .rspProtFault(rspProtFault),
  .rspHitVec(rspHitVec), .faultStatus(faultStatus)
);

// File: tb/test_multisize_tlb.sv
module test_multisize_tlb;
  localparam int ClkPeriod = 10;
  localparam int N = 64;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 0; logic [5:0] wrIdx = 0; logic [63:0] wrVa = 0; logic [12:0] wrCtx = 0;
  logic [40:0] wrPa = 0; logic [1:0] wrSize = 0; logic [6:0] wrFlags = 0;
  logic lkValid = 0; logic [63:0] lkVa = 0; logic [1:0] lkCtxSel = 0, lkKind = 0;
  logic lkUser = 0, lkBypass = 0, statusClr = 0;
  logic [12:0] ctxPrimary = 13'd5, ctxSecondary = 13'd9;
  logic rspValid, rspWritable, rspSwap, rspMiss, rspAccessFault, rspProtFault;
  logic [40:0] rspPa; logic [N-1:0] rspHitVec, entryUsed;
  logic [8:0] faultStatus; logic [63:0] faultAddr, tagAccess;

  int checks = 0, errors = 0;

  logic [63:0] bVa [N]; logic [40:0] bPa [N]; logic [12:0] bCtx [N];
  logic [1:0] bSz [N]; logic [6:0] bFl [N];
  logic [N-1:0] mUsed = '0; logic [8:0] mStat = '0;
  logic [63:0] mFAddr = '0, mTag = '0;

  always #(ClkPeriod/2) clk = ~clk;

  multisize_tlb i_multisize_tlb (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic writeEntry(input int idx, input logic [63:0] va, input logic [12:0] ctx,
                            input logic [40:0] pa, input logic [1:0] sz, input logic [6:0] fl);
    @(negedge clk);
    wrEn = 1; wrIdx = 6'(idx); wrVa = va; wrCtx = ctx; wrPa = pa; wrSize = sz; wrFlags = fl;
    @(negedge clk);
    wrEn = 0;
    bVa[idx] = va; bCtx[idx] = ctx; bPa[idx] = pa; bSz[idx] = sz; bFl[idx] = fl;
    mUsed[idx] = 1'b0;
  endtask

  task automatic lookup(input logic [63:0] va, input logic [1:0] sel, input logic [1:0] kind,
                        input logic user, input logic byp, input logic clr);
    logic [12:0] ctx; logic [1:0] cty; int hitIdx, pb;
    logic [40:0] ePa; logic eWr, eSw, eMiss, eAcc, eProt, fP, fS, fN;
    logic [N-1:0] eHv; logic [63:0] off;
    ctx = (sel == 0) ? ctxPrimary : (sel == 1) ? ctxSecondary : 13'd0;
    cty = (sel == 0) ? 2'd0 : (sel == 1) ? 2'd1 : 2'd2;
    hitIdx = -1;
    ePa = 0; eWr = 0; eSw = 0; eMiss = 0; eAcc = 0; eProt = 0; eHv = 0; fP = 0; fS = 0; fN = 0;
    if (byp) begin
      ePa = va[40:0]; eWr = 1;
      if (clr) mStat = 0;
    end else begin
      for (int i = N - 1; i >= 0; i--) begin
        pb = 13 + 3 * int'(bSz[i]);
        if (bFl[i][0] && (bFl[i][1] || bCtx[i] == ctx) && ((va >> pb) == (bVa[i] >> pb)))
          hitIdx = i;
      end
      if (hitIdx < 0) begin
        eMiss = 1; mTag = {va[63:13], ctx};
        if (clr) mStat = 0;
      end else begin
        pb = 13 + 3 * int'(bSz[hitIdx]);
        off = (64'd1 << pb) - 64'd1;
        ePa = ((bPa[hitIdx] & ~off[40:0]) | (va[40:0] & off[40:0])) & ~41'h1FFF;
        eHv[hitIdx] = 1; eWr = bFl[hitIdx][3]; eSw = bFl[hitIdx][6];
        fP = user && bFl[hitIdx][2];
        fS = (kind == 3) && bFl[hitIdx][4];
        fN = (kind <= 1) && bFl[hitIdx][5];
        eAcc = fP | fS | fN;
        eProt = !eAcc && kind == 1 && !bFl[hitIdx][3];
        if (eAcc || eProt) begin
          mStat = {fN, fS, fP, !user, cty, kind == 2'd1, mStat[0], 1'b1};
          mFAddr = va; mTag = {va[63:13], ctx};
        end else begin
          mUsed[hitIdx] = 1;
          if (clr) mStat = 0;
        end
      end
    end
    @(negedge clk);
    lkValid = 1; lkVa = va; lkCtxSel = sel; lkKind = kind; lkUser = user; lkBypass = byp; statusClr = clr;
    @(negedge clk);
    lkValid = 0; statusClr = 0;
    chk("R13", "rspValid", 64'(rspValid), 64'd1);
    chk("R3", "rspPa", 64'(rspPa), 64'(ePa));
    chk("R6", "rspMiss", 64'(rspMiss), 64'(eMiss));
    chk("R5", "rspHitVec", rspHitVec, eHv);
    chk("R8", "rspAccessFault", 64'(rspAccessFault), 64'(eAcc));
    chk("R9", "rspProtFault", 64'(rspProtFault), 64'(eProt));
    chk("R11", "rspWritable", 64'(rspWritable), 64'(eWr));
    chk("R11", "rspSwap", 64'(rspSwap), 64'(eSw));
    chk("R11", "entryUsed", entryUsed, mUsed);
    chk("R10", "faultStatus", 64'(faultStatus), 64'(mStat));
    chk("R10", "faultAddr", faultAddr, mFAddr);
    chk("R6", "tagAccess", tagAccess, mTag);
    @(negedge clk);
    chk("R13", "rspValid idle", 64'(rspValid), 64'd0);
  endtask

  function automatic logic [63:0] poolVa(input int r);
    logic [63:0] hi [4] = '{64'h0000_0000_0000_0000, 64'hFFFF_8000_0000_0000,
                           64'h0000_0040_0000_0000, 64'h1234_5600_0000_0000};
    logic [63:0] mid [4] = '{64'h0, 64'h2000, 64'h1_0000, 64'h40_0000};
    return hi[r % 4] | mid[(r / 4) % 4];
  endfunction

  initial begin
    #(ClkPeriod * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) begin bVa[i] = 0; bPa[i] = 0; bCtx[i] = 0; bSz[i] = 0; bFl[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rspValid", 64'(rspValid), 0);
    chk("R1", "faultStatus", 64'(faultStatus), 0);
    chk("R1", "tagAccess", tagAccess, 0);
    chk("R1", "entryUsed", entryUsed, 0);
    lookup(64'h1000_2000, 2'd0, 2'd0, 0, 0, 0);           // R1 all invalid -> miss

    // R2 size 1 (64 KB): bit 15 inside page, bit 16 outside
    writeEntry(10, 64'h0000_0000_8000_0000, 13'd5, 41'h1_2340_0000, 2'd1, 7'b0001001);
    lookup(64'h0000_0000_8000_8abc, 2'd0, 2'd0, 0, 0, 0); // R2 hit
    lookup(64'h0000_0000_8001_0000, 2'd0, 2'd0, 0, 0, 0); // R2 miss
    // R4 context select: secondary ctx 9 misses, global entry hits any context
    lookup(64'h0000_0000_8000_0000, 2'd1, 2'd0, 0, 0, 0); // R4 miss
    writeEntry(20, 64'h0000_0000_8000_0000, 13'd0, 41'h0_5550_0000, 2'd3, 7'b0001011);
    lookup(64'h0000_0000_8000_0000, 2'd2, 2'd0, 0, 0, 0); // R4 nucleus, R5 lowest
    lookup(64'h0000_0000_8000_0000, 2'd0, 2'd0, 0, 0, 0); // R5 both hit, entry 10 wins
    // R7 privilege, R9 protection, R8 no-fault-only and side-effect, R10 overwrite
    writeEntry(30, 64'h0000_00AA_0000_0000, 13'd5, 41'h0_7770_0000, 2'd0, 7'b1110101);
    lookup(64'h0000_00AA_0000_0000, 2'd0, 2'd1, 1, 0, 0); // R7 R8 multiple bits
    lookup(64'h0000_00AA_0000_0000, 2'd0, 2'd3, 0, 0, 0); // R8 side-effect, R10 overwrite
    lookup(64'h0000_00AA_0000_0000, 2'd0, 2'd2, 0, 0, 1); // R8 fetch ok, R11 swap+used, clr
    writeEntry(31, 64'h0000_00BB_0000_0000, 13'd5, 41'h0_1110_0000, 2'd0, 7'b0000001);
    lookup(64'h0000_00BB_0000_0000, 2'd0, 2'd1, 0, 0, 0); // R9 protection
    lookup(64'hDEAD_BEEF_CAFE_1234, 2'd0, 2'd1, 1, 1, 1); // R12 bypass
    writeEntry(30, 64'h0000_00AA_0000_0000, 13'd5, 41'h0_7770_0000, 2'd0, 7'b1000001); // R11 clears used

    // Random phase
    for (int i = 0; i < N; i++)
      writeEntry(i, poolVa(int'($urandom % 16)), ($urandom % 2) ? 13'd5 : 13'd9,
                 41'($urandom) << 13 | 41'(($urandom % 256)) << 32, 2'($urandom),
                 7'($urandom) | 7'(($urandom % 4) != 0));
    for (int k = 0; k < 400; k++) begin
      if (k % 100 == 50) begin
        ctxPrimary = ($urandom % 2) ? 13'd9 : 13'd5;
        ctxSecondary = ($urandom % 2) ? 13'd9 : 13'd5;
      end
      lookup(poolVa(int'($urandom % 16)) | 64'($urandom % 32'h1_0000),
             2'($urandom), 2'($urandom), 1'($urandom), ($urandom % 10) == 0,
             ($urandom % 4) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule